// File: doc/BRIEF.md
# ALU with Operation Decoder and Inequality Branch Mode

This block merges the operation decoder and the 32-bit arithmetic/logic unit of a single-cycle load/store datapath into one combinational module. Main control supplies a 3-bit operation class. For register-register instructions the 6-bit function field refines that class. The block returns the computed value and a zero flag that feeds the branch decision. It also exposes the 4-bit internal operation code so the selected operation can be observed.

Besides add, subtract, AND, OR, XOR, NOR and signed set-less-than, the block offers two further groups of behaviour. The first is a group of immediate logical operations that treat operand B as a zero-extended 16-bit quantity. The second is an inequality mode that raises the zero flag when the operands differ. In the inequality mode a branch-if-not-equal can travel the same path as branch-if-equal, and the datapath needs no change.

Top module: `alu_opdec`

## Requirements
- R1: The operation class selects the internal code: 0 gives 0x2 (add), 1 gives 0x6 (subtract), 3 gives 0x2 (add), 4 gives 0x4, 5 gives 0x5, 6 gives 0x8, and 7 gives 0xA (inequality), whatever the function field holds.
- R2: With operation class 2 the function field is decoded. 0x20 gives add (0x2), 0x22 gives subtract (0x6), 0x24 gives AND (0x0), 0x25 gives OR (0x1), 0x26 gives XOR (0x3), 0x27 gives NOR (0xC), and 0x2A gives set-less-than (0x7).
- R3: With operation class 2, any other function value gives code 0xF, a result of 0 and a zero flag of 1.
- R4: Add returns A+B and subtract returns A-B, both taken modulo 2^32.
- R5: AND, OR, XOR and NOR are applied bit by bit to the full 32-bit A and B.
- R6: Set-less-than returns 1 when A is below B as signed two's-complement numbers, and 0 otherwise.
- R7: Codes 0x4, 0x5 and 0x8 apply AND, OR and XOR respectively between A and B with B's upper 16 bits forced to zero.
- R8: For every code other than 0xA, the zero flag is 1 exactly when the 32-bit result is all zeros. In particular, subtracting equal operands raises it.
- R9: In code 0xA the result is A XOR B, and the zero flag is 1 when A and B differ and 0 when they are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 32 | Operand A |
| b_in | input | 32 | Operand B (register value or sign-extended immediate) |
| alu_op | input | 3 | Operation class from main control |
| funct | input | 6 | Function field for register-register instructions |
| result | output | 32 | Computed value |
| zero | output | 1 | Branch flag |
| ctl_code | output | 4 | Internal operation code |

## Verification
Every operation class, and all 64 function values, is applied to each ordered pair drawn from a small set of operands. The set contains 0, 1, all ones, the most negative and most positive numbers, a value whose bit 15 is set, and two mixed patterns. The equal pairs separate subtract from the inequality mode through the zero flag. The sign-boundary pairs separate signed from unsigned comparison in set-less-than. Operands with upper-half bits set and bit 15 set show whether the immediate logical modes mask B or sign-extend it. The function sweep confirms that every unlisted code falls to the undefined result.

// File: rtl/alu_opdec.sv
module alu_opdec #(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic [2:0]    alu_op,
  input  logic [5:0]    funct,
  output logic [DW-1:0] result,
  output logic          zero,
  output logic [3:0]    ctl_code
);
  localparam logic [3:0] C_AND  = 4'h0;
  localparam logic [3:0] C_OR   = 4'h1;
  localparam logic [3:0] C_ADD  = 4'h2;
  localparam logic [3:0] C_XOR  = 4'h3;
  localparam logic [3:0] C_ANDI = 4'h4;
  localparam logic [3:0] C_ORI  = 4'h5;
  localparam logic [3:0] C_SUB  = 4'h6;
  localparam logic [3:0] C_SLT  = 4'h7;
  localparam logic [3:0] C_XORI = 4'h8;
  localparam logic [3:0] C_NE   = 4'hA;
  localparam logic [3:0] C_NOR  = 4'hC;
  localparam logic [3:0] C_BAD  = 4'hF;

  wire [DW-1:0] b_zx = {{(DW-IW){1'b0}}, b_in[IW-1:0]};
  wire          lt   = $signed(a_in) < $signed(b_in);

  logic [3:0]    ctl;
  logic [DW-1:0] res;
  logic          zf;

  always_comb begin
    unique case (alu_op)
      3'd0: ctl = C_ADD;
      3'd1: ctl = C_SUB;
      3'd2: begin
        case (funct)
          6'h20:   ctl = C_ADD;
          6'h22:   ctl = C_SUB;
          6'h24:   ctl = C_AND;
          6'h25:   ctl = C_OR;
          6'h26:   ctl = C_XOR;
          6'h27:   ctl = C_NOR;
          6'h2A:   ctl = C_SLT;
          default: ctl = C_BAD;
        endcase
      end
      3'd3: ctl = C_ADD;
      3'd4: ctl = C_ANDI;
      3'd5: ctl = C_ORI;
      3'd6: ctl = C_XORI;
      default: ctl = C_NE;
    endcase

    case (ctl)
      C_ADD:   res = a_in + b_in;
      C_SUB:   res = a_in - b_in;
      C_AND:   res = a_in & b_in;
      C_OR:    res = a_in | b_in;
      C_XOR:   res = a_in ^ b_in;
      C_NOR:   res = ~(a_in | b_in);
      C_SLT:   res = {{(DW-1){1'b0}}, lt};
      C_ANDI:  res = a_in & b_zx;
      C_ORI:   res = a_in | b_zx;
      C_XORI:  res = a_in ^ b_zx;
      C_NE:    res = a_in ^ b_in;
      default: res = '0;
    endcase

    zf = (ctl == C_NE) ? (a_in != b_in) : (res == '0);

    p_op7_ne_r1: assert (alu_op != 3'd7 || ctl == C_NE);
    p_bad_zero_r3: assert (ctl != C_BAD || (res == '0 && zf));
    p_slt_bit_r6: assert (ctl != C_SLT || res[DW-1:1] == '0);
    p_andi_hi_r7: assert (ctl != C_ANDI || res[DW-1:IW] == '0);
    p_ori_hi_r7: assert (!(ctl == C_ORI || ctl == C_XORI) || res[DW-1:IW] == a_in[DW-1:IW]);
    p_sub_eq_r8: assert (!(ctl == C_SUB && a_in == b_in) || zf);
    p_ne_flag_r9: assert (ctl != C_NE || zf == (res != '0));
  end

  assign result   = res;
  assign zero     = zf;
  assign ctl_code = ctl;
endmodule

// File: tb/tb_alu_opdec.sv
`timescale 1ns/1ps
module tb_alu_opdec;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] a_in = '0, b_in = '0;
  logic [2:0]  alu_op = '0;
  logic [5:0]  funct = '0;
  logic [31:0] result;
  logic        zero;
  logic [3:0]  ctl_code;

  int checks = 0, errors = 0;
  logic done = 1'b0;

  alu_opdec dut (.a_in(a_in), .b_in(b_in), .alu_op(alu_op), .funct(funct),
                 .result(result), .zero(zero), .ctl_code(ctl_code));

  logic [31:0] vals [8];
  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
    vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h8000_0000;
    vals[4] = 32'h7FFF_FFFF; vals[5] = 32'h0001_8000;
    vals[6] = 32'hDEAD_BEEF; vals[7] = 32'h0000_FFFF;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d fn=%h a=%h b=%h actual=%h expected=%h",
               tag, alu_op, funct, a_in, b_in, act, exp);
    end
  endtask

  task automatic run_one(input logic [31:0] a, input logic [31:0] b,
                         input logic [2:0] op, input logic [5:0] fn);
    logic [3:0] ec; logic [31:0] er; logic ez; string ct, rt, zt;
    logic [31:0] bz;
    @(negedge clk);
    a_in = a; b_in = b; alu_op = op; funct = fn;
    @(posedge clk); #1;
    bz = {16'h0, b[15:0]};
    ct = "R1"; zt = "R8";
    case (op)
      3'd0, 3'd3: begin ec = 4'h2; er = a + b; rt = "R4"; end
      3'd1: begin ec = 4'h6; er = a - b; rt = "R4"; end
      3'd4: begin ec = 4'h4; er = a & bz; rt = "R7"; end
      3'd5: begin ec = 4'h5; er = a | bz; rt = "R7"; end
      3'd6: begin ec = 4'h8; er = a ^ bz; rt = "R7"; end
      3'd7: begin ec = 4'hA; er = a ^ b; rt = "R9"; zt = "R9"; end
      default: begin
        ct = "R2";
        case (fn)
          6'h20: begin ec = 4'h2; er = a + b; rt = "R4"; end
          6'h22: begin ec = 4'h6; er = a - b; rt = "R4"; end
          6'h24: begin ec = 4'h0; er = a & b; rt = "R5"; end
          6'h25: begin ec = 4'h1; er = a | b; rt = "R5"; end
          6'h26: begin ec = 4'h3; er = a ^ b; rt = "R5"; end
          6'h27: begin ec = 4'hC; er = ~(a | b); rt = "R5"; end
          6'h2A: begin ec = 4'h7; rt = "R6";
            er = ((a[31] & ~b[31]) | ((a[31] == b[31]) & (a < b))) ? 32'd1 : 32'd0; end
          default: begin ec = 4'hF; er = 32'd0; rt = "R3"; ct = "R3"; zt = "R3"; end
        endcase
      end
    endcase
    ez = (op == 3'd7) ? (a != b) : (er == 32'd0);
    chk(ct, {28'h0, ctl_code}, {28'h0, ec});
    chk(rt, result, er);
    chk(zt, {31'h0, zero}, {31'h0, ez});
  endtask

  initial begin
    #2;
    chk("R1", {28'h0, ctl_code}, 32'h2);
    chk("R8", {31'h0, zero}, 32'h1);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        for (int op = 0; op < 8; op++)
          if (op != 2) run_one(vals[i], vals[j], 3'(op), 6'(i * 8 + j));
        for (int fn = 0; fn < 64; fn++)
          run_one(vals[i], vals[j], 3'd2, 6'(fn));
      end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule